// File: doc/BRIEF.md
# Flagged Bit-Run Configuration Decompressor

This block expands a compressed byte stream into the serial bit stream that an FPGA loaded one bit at a time expects on its data pin. Every input byte carries a one-bit flag in its most significant position. With the flag clear, the other seven bits are configuration data passed through unchanged. With the flag set, the byte stands for a run of identical bits, and a single byte can then replace up to 63 bits. Configuration images hold long stretches of all ones or all zeros, and this scheme compresses them while the decoder stays very small.

Bytes enter over a valid/ready handshake. Bits leave one per output handshake, so a separate pin driver can pair each bit with its configuration clock edge. The block takes a new byte only when the bits of the previous byte have all gone downstream, so the output order always matches the input order. A running bit count lets the consumer compare the number of bits produced with the expected image length. A sticky flag marks any run byte whose length field is zero.

Top module: `bitrun_unpacker`

## Requirements
- R1: A byte with bit 7 = 0 is a literal. Its bits 6 down to 0 are output in that order, bit 6 first, one bit per output handshake.
- R2: A byte with bit 7 = 1 is a run. Bit 6 gives the bit value and bits 5:0 give the length N. The block outputs N copies of that value.
- R3: Run lengths from 1 up to the maximum of 63 are all produced in full (bytes 0xFF and 0xBF each give 63 bits).
- R4: A run byte with length 0 (0x80 or 0xC0) is consumed but outputs no bit, and it sets `err_zero_run`.
- R5: `in_ready` is high only when no bit of an earlier byte is outstanding, or when the last outstanding bit is being accepted in the same cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_bit` holds its value.
- R7: `bit_count` equals the number of output handshakes completed since reset, modulo 2^CNT_W.
- R8: A synchronous reset clears the pending bits, the run state, `bit_count` and `err_zero_run`, and leaves `in_ready` = 1 and `out_valid` = 0.
- R9: Once set, `err_zero_run` stays set until reset, whatever bytes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Compressed byte present |
| in_ready | output | 1 | Block takes the byte this cycle |
| in_byte | input | LIT_W+1 (8) | Compressed byte: flag, then literal bits or value and length |
| out_valid | output | 1 | A configuration bit is present |
| out_ready | input | 1 | Consumer accepts the bit this cycle |
| out_bit | output | 1 | Configuration data bit |
| bit_count | output | CNT_W (24) | Bits output since reset |
| err_zero_run | output | 1 | Sticky: a zero-length run byte was seen |

## Verification
The bench builds the block with its default parameters: seven literal bits per byte, a six-bit run length and a 24-bit counter. With these values the 63-bit maximum run and both run polarities can be tested, and the literal chunks appear in full. The consumer runs in three readiness patterns (always ready, alternating, and one stall in three). Under these patterns the bench compares the ready-while-last-bit overlap and the stall hold against a model of the outstanding bits. Zero-length run bytes are placed between valid bytes, and the bench checks that they are silent, that the error flag stays set afterwards, and that reset clears it.

// File: rtl/bru_pkg.sv
package bru_pkg;
   typedef enum logic [1:0] {
      KIND_LIT   = 2'd0,
      KIND_RUN   = 2'd1,
      KIND_EMPTY = 2'd2
   } kind_e;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
   import bru_pkg::*;
#(
   parameter int LIT_W = 7
) (
   input  logic [LIT_W:0]   byte_i,
   output kind_e            kind_o,
   output logic             run_val_o,
   output logic [LIT_W-1:0] lit_o,
   output logic [LIT_W-1:0] len_o
);
   localparam int LEN_W = LIT_W - 1;

   generate
      if (LIT_W < 2) begin : g_bad_width
         $error("bru_decode: LIT_W must be at least 2");
      end
   endgenerate

   logic [LEN_W-1:0] run_len;
   assign run_len = byte_i[LEN_W-1:0];

   always_comb begin
      lit_o     = byte_i[LIT_W-1:0];
      run_val_o = byte_i[LIT_W-1];
      if (!byte_i[LIT_W]) begin
         kind_o = KIND_LIT;
         len_o  = LIT_W[LIT_W-1:0];
      end else if (run_len == '0) begin
         kind_o = KIND_EMPTY;
         len_o  = '0;
      end else begin
         kind_o = KIND_RUN;
         len_o  = {1'b0, run_len};
      end
   end
endmodule

// File: rtl/bru_engine.sv
module bru_engine
   import bru_pkg::*;
#(
   parameter int LIT_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             is_run_i,
   input  logic             run_val_i,
   input  logic [LIT_W-1:0] lit_i,
   input  logic [LIT_W-1:0] len_i,
   input  logic             out_ready_i,
   output logic             out_valid_o,
   output logic             out_bit_o,
   output logic             last_o,
   output logic             fire_o
);
   localparam int RUN_MAX = (1 << (LIT_W - 1)) - 1;
   localparam int CNT_MAX = (RUN_MAX > LIT_W) ? RUN_MAX : LIT_W;

   logic             busy;
   logic             is_run;
   logic             run_val;
   logic [LIT_W-1:0] shreg;
   logic [LIT_W-1:0] remain;

   assign out_valid_o = busy;
   assign out_bit_o   = is_run ? run_val : shreg[LIT_W-1];
   assign fire_o      = busy & out_ready_i;
   assign last_o      = (remain == LIT_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         is_run  <= 1'b0;
         run_val <= 1'b0;
         shreg   <= '0;
         remain  <= '0;
      end else if (load_i) begin
         busy    <= 1'b1;
         is_run  <= is_run_i;
         run_val <= run_val_i;
         shreg   <= lit_i;
         remain  <= len_i;
      end else if (fire_o) begin
         remain <= remain - LIT_W'(1);
         shreg  <= {shreg[LIT_W-2:0], 1'b0};
         if (last_o) busy <= 1'b0;
      end
   end

   // R6: a stalled bit is held
   assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (busy && !out_ready_i) |=> (busy && $stable(out_bit_o)));

   // R5: a byte is loaded only when nothing earlier is still pending
   assert_load_order_R5: assert property (@(posedge clk) disable iff (rst)
      load_i |-> (!busy || (fire_o && last_o)));

   // R3: the pending count stays inside the legal range
   assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
      busy |-> (remain != '0 && int'(remain) <= CNT_MAX));
endmodule

// File: rtl/bru_bitcount.sv
module bru_bitcount #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("bru_bitcount: CNT_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)        count_o <= '0;
      else if (inc_i) count_o <= count_o + CNT_W'(1);
   end
endmodule

// File: rtl/bitrun_unpacker.sv
module bitrun_unpacker
   import bru_pkg::*;
#(
   parameter int LIT_W = 7,
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [LIT_W:0]   in_byte,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_bit,
   output logic [CNT_W-1:0] bit_count,
   output logic             err_zero_run
);
   kind_e            kind;
   logic             run_val;
   logic [LIT_W-1:0] lit;
   logic [LIT_W-1:0] len;
   logic             last;
   logic             fire;
   logic             accept;
   logic             load;

   bru_decode #(.LIT_W(LIT_W)) u_decode (
      .byte_i    (in_byte),
      .kind_o    (kind),
      .run_val_o (run_val),
      .lit_o     (lit),
      .len_o     (len)
   );

   assign in_ready = !out_valid || (fire && last);
   assign accept   = in_valid && in_ready;
   assign load     = accept && (kind != KIND_EMPTY);

   bru_engine #(.LIT_W(LIT_W)) u_engine (
      .clk         (clk),
      .rst         (rst),
      .load_i      (load),
      .is_run_i    (kind == KIND_RUN),
      .run_val_i   (run_val),
      .lit_i       (lit),
      .len_i       (len),
      .out_ready_i (out_ready),
      .out_valid_o (out_valid),
      .out_bit_o   (out_bit),
      .last_o      (last),
      .fire_o      (fire)
   );

   bru_bitcount #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst     (rst),
      .inc_i   (fire),
      .count_o (bit_count)
   );

   always_ff @(posedge clk) begin
      if (rst)                                err_zero_run <= 1'b0;
      else if (accept && kind == KIND_EMPTY)  err_zero_run <= 1'b1;
   end

   // R4: an empty run byte produces no bit
   assert_empty_silent_R4: assert property (@(posedge clk) disable iff (rst)
      (accept && kind == KIND_EMPTY) |=> (!out_valid && err_zero_run));

   // R9: the error flag is sticky
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      err_zero_run |=> err_zero_run);

   // R7: each output handshake advances the count by one
   assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready) |=> (bit_count == $past(bit_count) + CNT_W'(1)));
endmodule

// File: tb/bitrun_unpacker_bench.sv
module bitrun_unpacker_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        in_ready;
   logic [7:0]  in_byte;
   logic        out_valid;
   logic        out_ready;
   logic        out_bit;
   logic [23:0] bit_count;
   logic        err_zero_run;

   int checks = 0;
   int errors = 0;
   int total_bits = 0;

   logic [7:0] stim [64];
   int         nstim;
   bit         expq [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bitrun_unpacker u_bitrun_unpacker (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
      .out_bit(out_bit), .bit_count(bit_count), .err_zero_run(err_zero_run)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int bits_of(input logic [7:0] b);
      if (!b[7]) return 7;
      return int'(b[5:0]);
   endfunction

   function automatic void expand(input logic [7:0] b);
      if (!b[7]) begin
         for (int i = 6; i >= 0; i--) expq.push_back(b[i]);
      end else begin
         for (int i = 0; i < int'(b[5:0]); i++) expq.push_back(b[6]);
      end
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; in_byte = '0; out_ready = 1'b0;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      total_bits = 0;
   endtask

   // mode 0: always ready, 1: alternating, 2: stall one cycle in three
   task automatic run_stream(input string req, input int mode, input bit exp_err);
      int idx = 0, outstanding = 0, rcv = 0, bad = 0, cyc = 0, nexp;
      bit prev_stall = 0, prev_bit = 0, r5_ok = 1, r6_ok = 1;
      expq.delete();
      for (int i = 0; i < nstim; i++) expand(stim[i]);
      nexp = expq.size();
      while ((idx < nstim || outstanding > 0) && cyc < 5000) begin
         bit acc, got, exp_ready;
         @(negedge clk);
         out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : ((cyc % 3) != 0);
         in_valid  = (idx < nstim);
         in_byte   = (idx < nstim) ? stim[idx] : 8'h00;
         #1;
         exp_ready = (outstanding == 0) || (outstanding == 1 && out_ready);
         if (in_ready !== exp_ready || out_valid !== (outstanding > 0)) r5_ok = 0;
         if (prev_stall && (out_valid !== 1'b1 || out_bit !== prev_bit)) r6_ok = 0;
         acc = in_valid && in_ready;
         got = out_valid && out_ready;
         if (got) begin
            if (rcv >= nexp || out_bit !== expq[rcv]) bad++;
            rcv++;
         end
         prev_stall = out_valid && !out_ready;
         prev_bit   = out_bit;
         @(posedge clk);
         if (got) outstanding--;
         if (acc) begin
            outstanding += bits_of(stim[idx]);
            idx++;
         end
         cyc++;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b0;
      #1;
      total_bits += rcv;
      check(bad == 0, {req, " bit values"}, bad, 0);
      check(rcv == nexp, {req, " bit total"}, rcv, nexp);
      check(r5_ok, "R5 in_ready ordering", int'(r5_ok), 1);
      if (mode != 0) check(r6_ok, "R6 stall hold", int'(r6_ok), 1);
      check(int'(bit_count) == total_bits, "R7 bit_count", int'(bit_count), total_bits);
      check(err_zero_run == exp_err, "R4/R9 err_zero_run", int'(err_zero_run), int'(exp_err));
      check(out_valid == 1'b0, {req, " idle after stream"}, int'(out_valid), 0);
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check(in_ready == 1'b1, "R8 in_ready after reset", int'(in_ready), 1);
      check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
      check(bit_count == '0, "R8 bit_count after reset", int'(bit_count), 0);
      check(err_zero_run == 1'b0, "R8 err after reset", int'(err_zero_run), 0);
   endtask

   task automatic t_literal();
      stim[0] = 8'h5A; stim[1] = 8'h01; stim[2] = 8'h7F; stim[3] = 8'h00; stim[4] = 8'h40;
      nstim = 5;
      run_stream("R1 literal", 0, 1'b0);
   endtask

   task automatic t_runs();
      stim[0] = 8'hC5; stim[1] = 8'h83; stim[2] = 8'hC1; stim[3] = 8'h81; stim[4] = 8'h2B;
      stim[5] = 8'hC2;
      nstim = 6;
      run_stream("R2 runs", 1, 1'b0);
   endtask

   task automatic t_long();
      stim[0] = 8'hFF; stim[1] = 8'hBF; stim[2] = 8'h2A; stim[3] = 8'hFF;
      nstim = 4;
      run_stream("R3 max runs", 2, 1'b0);
   endtask

   task automatic t_backpressure();
      for (int i = 0; i < 12; i++) stim[i] = (i % 2 == 0) ? 8'(8'h11 * i + 3) : 8'(8'hC0 | (i + 1));
      nstim = 12;
      run_stream("R5 mixed backpressure", 2, 1'b0);
   endtask

   task automatic t_empty();
      stim[0] = 8'h35; stim[1] = 8'h80; stim[2] = 8'hC3; stim[3] = 8'hC0; stim[4] = 8'h66;
      nstim = 5;
      run_stream("R4 empty run", 1, 1'b1);
      stim[0] = 8'h9; stim[1] = 8'hC4;
      nstim = 2;
      run_stream("R9 after error", 0, 1'b1);
      do_reset();
      #1;
      check(err_zero_run == 1'b0, "R8 err cleared by reset", int'(err_zero_run), 0);
      check(bit_count == '0, "R8 count cleared by reset", int'(bit_count), 0);
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_byte = '0; out_ready = 1'b0;
      t_reset();
      t_literal();
      t_runs();
      t_long();
      t_backpressure();
      t_empty();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule